// File: doc/BRIEF.md
# Peripheral bus cycle extension controller

This block sequences the bus clock strobe and the address controls for one processor-side peripheral bus and one user-memory bus. Its reference clock runs at twice the processor cycle rate. Each reference clock cycle is one half-cycle step, so each strobe phase can be placed to the nearest half cycle.

An access is presented with its kind (peripheral or user memory), its direction, a 5-bit peripheral register address and an optional wait-state request. Peripheral addresses 0x18 to 0x1F belong to the external bus. For those addresses the block asserts an external select and drives the three low address bits out.

An access can be stretched by one processor cycle in two ways:
- A wait state lengthens only the low phase of the strobe.
- An extended cycle lengthens both the high phase and the low phase by half a cycle each.

Two control bits choose extended cycles for each access type. Bit 7 applies to every user-memory access. Bit 13 applies to reads on the external peripheral bus. Reset clears both bits.

Top module: `pbus_stretch`

## Requirements
- R1: A peripheral access with address 0x18..0x1F asserts `ext_sel` for the whole access and drives `ext_addr` with address bits [2:0]. A peripheral access below 0x18, or any user-memory access, keeps `ext_sel` low and `ext_addr` at 0.
- R2: An unstretched access takes 2 steps: the strobe is high for 1 step and then low for 1 step. This is one processor cycle.
- R3: An access with `req_wait` high and no extension enabled takes 4 steps: the strobe is high for 1 step and then low for 3 steps.
- R4: An extended access takes 4 steps: the strobe is high for 2 steps and then low for 2 steps.
- R5: While control bit 7 is set, every user-memory access is extended, whatever its direction.
- R6: While control bit 13 is set, every read at addresses 0x18..0x1F is extended. Writes at those addresses, and accesses to addresses below 0x18, are not extended by bit 13.
- R7: Reset clears both extend bits. After reset, with no control write, accesses use the timing of R2 or R3.
- R8: When `req_wait` and an enabled extension apply to the same access, the access uses the timing of R4 (4 steps in total).
- R9: `done` is high only in the last step of each access. `rd_capture` is high in that same step for reads only.
- R10: While no access is in progress, the strobe is low, `busy` is low, `ext_sel` is low and `ext_addr` is 0. A request is accepted at a clock edge only while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one period is one half-cycle step |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Write strobe for the control bits |
| ctl_wdata | input | 16 | Control word; bit 7 enables user-memory extension, bit 13 enables external read extension |
| req_valid | input | 1 | Access request; accepted at an edge when `busy` is low |
| req_user | input | 1 | 1 = user-memory access, 0 = peripheral access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Peripheral register address |
| req_wait | input | 1 | Adds one wait state to this access |
| busy | output | 1 | Access in progress |
| bus_strobe | output | 1 | Bus clock strobe |
| ext_sel | output | 1 | External peripheral location selected |
| ext_addr | output | 3 | External address (low address bits) |
| done | output | 1 | Last step of the access |
| rd_capture | output | 1 | Read data is sampled in this step |

## Verification
The assertions assume two things about the inputs. Reset is applied before the first request. Request fields are used only in the cycle where `req_valid` is seen while `busy` is low. The bench follows both rules. It drives every request and every control write on the falling edge while the block is idle, and it drops `req_valid` before the accepted access ends. Random accesses and control words come from a fixed seed. They are mixed with directed cases: the reset state, the address boundary 0x17/0x18, and a wait-state request combined with an enabled extension.

// File: rtl/pbus_stretch.sv
module pbus_stretch #(
  parameter int AW          = 5,
  parameter int DW          = 16,
  parameter int EXT_BITS    = 3,
  parameter int CYC_EXT_BIT = 7,
  parameter int RD_EXT_BIT  = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_we,
  input  logic [DW-1:0]       ctl_wdata,
  input  logic                req_valid,
  input  logic                req_user,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic                req_wait,
  output logic                busy,
  output logic                bus_strobe,
  output logic                ext_sel,
  output logic [EXT_BITS-1:0] ext_addr,
  output logic                done,
  output logic                rd_capture
);
  localparam int TAG_W = AW - EXT_BITS;

  logic          cyc_ext_q, rd_ext_q;
  logic          busy_q, sym_q, long_q, user_q, write_q;
  logic [1:0]    step_q;
  logic [AW-1:0] addr_q;

  logic req_ext_hit, req_stretch, accept, hit_q;

  assign req_ext_hit = !req_user && (&req_addr[AW-1:EXT_BITS]);
  assign req_stretch = req_user ? cyc_ext_q : (req_ext_hit && !req_write && rd_ext_q);
  assign accept      = req_valid && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_ext_q <= 1'b0;
      rd_ext_q  <= 1'b0;
    end else if (ctl_we) begin
      cyc_ext_q <= ctl_wdata[CYC_EXT_BIT];
      rd_ext_q  <= ctl_wdata[RD_EXT_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      step_q  <= 2'd0;
      sym_q   <= 1'b0;
      long_q  <= 1'b0;
      user_q  <= 1'b0;
      write_q <= 1'b0;
      addr_q  <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      step_q  <= 2'd0;
      sym_q   <= req_stretch;
      long_q  <= req_stretch || req_wait;
      user_q  <= req_user;
      write_q <= req_write;
      addr_q  <= req_addr;
    end else if (busy_q) begin
      if (done) busy_q <= 1'b0;
      else      step_q <= step_q + 2'd1;
    end
  end

  assign hit_q      = !user_q && (addr_q[AW-1:EXT_BITS] == {TAG_W{1'b1}});
  assign busy       = busy_q;
  assign bus_strobe = busy_q && (sym_q ? (step_q < 2'd2) : (step_q == 2'd0));
  assign done       = busy_q && (step_q == (long_q ? 2'd3 : 2'd1));
  assign rd_capture = done && !write_q;
  assign ext_sel    = busy_q && hit_q;
  assign ext_addr   = ext_sel ? addr_q[EXT_BITS-1:0] : '0;

  a_r9_done_ends_access: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r4_ext_high_two_steps: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_strobe) && sym_q |=> bus_strobe);

  a_r3_wait_low_three_steps: assert property (@(posedge clk) disable iff (!rst_n)
    busy && long_q && !sym_q && $fell(bus_strobe) |=> busy && !bus_strobe && !done);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_strobe && !ext_sel && ext_addr == '0);

  a_r1_ext_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(done) |-> $stable(ext_addr) && $stable(ext_sel));

  a_r2_strobe_starts_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> bus_strobe);

  a_r7_bits_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !cyc_ext_q && !rd_ext_q);
endmodule

// File: tb/pbus_stretch_bench.sv
module pbus_stretch_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic req_valid = 1'b0, req_user = 1'b0, req_write = 1'b0, req_wait = 1'b0;
  logic [4:0] req_addr = '0;
  logic busy, bus_strobe, ext_sel, done, rd_capture;
  logic [2:0] ext_addr;

  int checks = 0, errors = 0;
  bit m_ce = 0, m_re = 0;
  bit finished = 0;

  pbus_stretch u_pbus_stretch (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .req_valid(req_valid), .req_user(req_user), .req_write(req_write),
    .req_addr(req_addr), .req_wait(req_wait), .busy(busy),
    .bus_strobe(bus_strobe), .ext_sel(ext_sel), .ext_addr(ext_addr),
    .done(done), .rd_capture(rd_capture)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit is_ext(bit user, logic [4:0] a);
    return !user && a >= 5'h18;
  endfunction

  function automatic bit exp_sym(bit user, bit wr, logic [4:0] a);
    return user ? m_ce : (is_ext(user, a) && !wr && m_re);
  endfunction

  function automatic int exp_len(bit user, bit wr, logic [4:0] a, bit w);
    return (exp_sym(user, wr, a) || w) ? 4 : 2;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ctl_write(logic [15:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
    m_ce = v[7]; m_re = v[13];
  endtask

  task automatic access(bit user, bit wr, logic [4:0] a, bit w, string tag);
    int len = 0, hi = 0, lead = 0, done_cnt = 0, done_at = -1, cap = 0;
    int sel_bad = 0;
    bit ext;
    int el, eh;
    ext = is_ext(user, a);
    el = exp_len(user, wr, a, w);
    eh = exp_sym(user, wr, a) ? 2 : 1;
    @(negedge clk);
    req_valid = 1'b1; req_user = user; req_write = wr; req_addr = a; req_wait = w;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (!busy) break;
      len++;
      if (bus_strobe) begin hi++; if (lead == i) lead++; end
      if (done) begin done_cnt++; done_at = i; cap = rd_capture; end
      else if (rd_capture) sel_bad++;
      if (ext_sel != ext || ext_addr != (ext ? a[2:0] : 3'd0)) sel_bad++;
      @(negedge clk);
    end
    check(len == el, {tag, " length"}, len, el);
    check(hi == eh && lead == eh, {tag, " high steps"}, hi, eh);
    check(done_cnt == 1 && done_at == el - 1, "R9 done in last step", done_at, el - 1);
    check(cap == !wr, "R9 rd_capture on reads", cap, !wr);
    check(sel_bad == 0, "R1 external select/address", sel_bad, 0);
    check(!busy && !bus_strobe && !ext_sel && ext_addr == 0, "R10 idle after access",
          {busy, bus_strobe, ext_sel}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!busy && !bus_strobe && !ext_sel && ext_addr == 0 && !done, "R10 reset idle",
          {busy, bus_strobe, ext_sel, done}, 0);
    rst_n = 1'b1;
    access(1, 0, 5'h00, 0, "R7 user read after reset normal");
    access(0, 0, 5'h1F, 0, "R7 external read after reset normal");
    access(0, 1, 5'h03, 0, "R2 internal write");
    access(0, 0, 5'h17, 0, "R1 boundary 0x17");
    access(0, 0, 5'h18, 0, "R1 boundary 0x18");
    access(1, 1, 5'h05, 1, "R3 wait state user");
    ctl_write(16'h0080);
    access(1, 1, 5'h02, 0, "R5 user write extended");
    access(1, 0, 5'h02, 0, "R5 user read extended");
    access(0, 0, 5'h1A, 0, "R6 bit7 does not extend external read");
    ctl_write(16'h2000);
    access(0, 0, 5'h1C, 0, "R6 external read extended");
    access(0, 1, 5'h1C, 0, "R6 external write not extended");
    access(0, 0, 5'h10, 0, "R6 internal read not extended");
    access(1, 0, 5'h1C, 0, "R6 bit13 does not extend user");
    access(0, 0, 5'h1E, 1, "R8 wait plus extend");
    ctl_write(16'h2080);
    access(1, 1, 5'h00, 1, "R8 wait plus user extend");
    access(0, 0, 5'h19, 0, "R4 extended read");
    rst_n = 1'b0; m_ce = 0; m_re = 0;
    @(negedge clk);
    rst_n = 1'b1;
    access(1, 0, 5'h00, 0, "R7 user normal after second reset");
    access(0, 0, 5'h1B, 0, "R7 external read normal after second reset");
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 9) == 0) ctl_write(16'($urandom()));
      access(1'($urandom()), 1'($urandom()), 5'($urandom()), 1'($urandom_range(0, 3) == 0),
             "R2-random timing");
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule